// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit device-side virtual address into a physical address by reading descriptors from a two-level table held in ordinary memory. A client presents an address together with a one-cycle request strobe. The walker fetches one descriptor word from the first-level table. If that descriptor names a second-level table, it fetches one more word. It then reports the outcome with a single-cycle `done` pulse. The outcome is either a physical address or a fault code, and on a fault the block also keeps the virtual address that failed.

Three mapping sizes are handled: 1 MB sections resolved at the first level, and 64 KB or 4 KB pages resolved at the second level. A 64 KB page occupies sixteen repeated second-level slots, so any of those slots yields the same result. The block reads memory through a plain strobe/response port with at most one read in flight. A response flagged as an error terminates the walk. The block does no caching and no permission checking.

Top module: `iova_table_walker`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `fault_code` are all 0.
- R2: An accepted request starts exactly one first-level read at `tbl_base + va[31:20]*4`. `mem_req` is high for a single cycle per read, and a new read is never issued before the previous one has returned.
- R3: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk with `fault_code` = 1 after that single read.
- R4: A first-level descriptor with bits [1:0] = 2 ends the walk with `fault_code` = 0 and `phys_addr` = {desc[31:20], va[19:0]}. Descriptor bits [19:2] have no effect.
- R5: A first-level descriptor with bits [1:0] = 1 causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 0 ends the walk with `fault_code` = 2.
- R7: A second-level descriptor with bits [1:0] = 1 gives `phys_addr` = {desc[31:16], va[15:0]}. All sixteen slots of a 64 KB page translate alike.
- R8: A second-level descriptor with bit 1 set (type 2 or 3) gives `phys_addr` = {desc[31:12], va[11:0]}.
- R9: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse during which `busy` is low. On any nonzero `fault_code`, `fault_va` equals the requested address.
- R10: A read response with `mem_rerr` set, at either level, ends the walk with `fault_code` = 3 and issues no further reads.
- R11: `req_valid` while `busy` is ignored. The running walk's reads and result are unchanged, and no walk starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request strobe, taken when not busy |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Translated address, valid when `fault_code` is 0 |
| fault_code | output | 2 | 0 ok, 1 first-level fault, 2 second-level fault, 3 bus error |
| fault_va | output | 32 | Virtual address of the last faulting walk |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Word address of the read |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 32 | Returned descriptor word |
| mem_rerr | input | 1 | Error flag for the returned word |

## Verification
The assertions assume that `mem_rvalid` rises only once per issued read, and only after that read's strobe. Under this assumption, each response observed while waiting can be tied to the level currently being fetched. The bench memory model enforces the assumption: it returns exactly one word per captured `mem_req`, after a latency of one to three cycles. The model computes descriptor contents from the address, so the first-level table, the second-level tables and the error injection point are all defined arithmetically.

// File: rtl/iova_table_walker.sv
module iova_table_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tbl_base,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        busy,
  output logic        done,
  output logic [31:0] phys_addr,
  output logic [1:0]  fault_code,
  output logic [31:0] fault_va,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr
);

  localparam logic [1:0] FC_OK  = 2'd0;
  localparam logic [1:0] FC_L1  = 2'd1;
  localparam logic [1:0] FC_L2  = 2'd2;
  localparam logic [1:0] FC_BUS = 2'd3;

  typedef enum logic [1:0] {W_IDLE, W_LVL1, W_LVL2} wstate_t;

  wstate_t     state;
  logic [31:0] va_q;

  wire [1:0] kind      = mem_rdata[1:0];
  wire       got_l1    = (state == W_LVL1) && mem_rvalid;
  wire       got_l2    = (state == W_LVL2) && mem_rvalid;
  wire       l1_sect   = kind == 2'b10;
  wire       l1_table  = kind == 2'b01;
  wire       l2_fault  = kind == 2'b00;
  wire       l2_large  = kind == 2'b01;

  logic unused_attr_bits;
  assign unused_attr_bits = ^mem_rdata[9:2];

  assign busy = state != W_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= W_IDLE;
      va_q       <= '0;
      done       <= 1'b0;
      phys_addr  <= '0;
      fault_code <= FC_OK;
      fault_va   <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        W_IDLE: if (req_valid) begin
          va_q       <= req_va;
          phys_addr  <= '0;
          fault_code <= FC_OK;
          mem_req    <= 1'b1;
          mem_addr   <= tbl_base + {18'd0, req_va[31:20], 2'b00};
          state      <= W_LVL1;
        end
        W_LVL1: if (mem_rvalid) begin
          if (mem_rerr) begin
            fault_code <= FC_BUS;
            fault_va   <= va_q;
            done       <= 1'b1;
            state      <= W_IDLE;
          end else if (l1_sect) begin
            phys_addr <= {mem_rdata[31:20], va_q[19:0]};
            done      <= 1'b1;
            state     <= W_IDLE;
          end else if (l1_table) begin
            mem_req  <= 1'b1;
            mem_addr <= {mem_rdata[31:10], va_q[19:12], 2'b00};
            state    <= W_LVL2;
          end else begin
            fault_code <= FC_L1;
            fault_va   <= va_q;
            done       <= 1'b1;
            state      <= W_IDLE;
          end
        end
        W_LVL2: if (mem_rvalid) begin
          done  <= 1'b1;
          state <= W_IDLE;
          if (mem_rerr) begin
            fault_code <= FC_BUS;
            fault_va   <= va_q;
          end else if (l2_fault) begin
            fault_code <= FC_L2;
            fault_va   <= va_q;
          end else if (l2_large) begin
            phys_addr <= {mem_rdata[31:16], va_q[15:0]};
          end else begin
            phys_addr <= {mem_rdata[31:12], va_q[11:0]};
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && mem_req)); // R2
  AST_L1_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (got_l1 && !mem_rerr && (kind == 2'b00 || kind == 2'b11)) |=> (done && fault_code == FC_L1 && !mem_req)); // R3
  AST_SECTION_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (got_l1 && !mem_rerr && l1_sect) |=> (done && fault_code == FC_OK && phys_addr[31:20] == $past(mem_rdata[31:20]))); // R4
  AST_L2_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (got_l1 && !mem_rerr && l1_table) |=> (mem_req && !done && mem_addr[31:10] == $past(mem_rdata[31:10]))); // R5
  AST_L2_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (got_l2 && !mem_rerr && l2_fault) |=> (done && fault_code == FC_L2)); // R6
  AST_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid && mem_rerr) |=> (done && fault_code == FC_BUS && !mem_req)); // R10
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !mem_rvalid) |=> !done); // R11

endmodule

// File: tb/iova_table_walker_tb.sv
module iova_table_walker_tb_top;
  localparam logic [31:0] L1_BASE = 32'h0004_0000;
  localparam logic [31:0] L2_AREA = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic busy, done, mem_req;
  logic [31:0] phys_addr, fault_va, mem_addr;
  logic [1:0] fault_code;
  logic mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  iova_table_walker dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_base(L1_BASE),
    .req_valid(req_valid), .req_va(req_va),
    .busy(busy), .done(done), .phys_addr(phys_addr),
    .fault_code(fault_code), .fault_va(fault_va),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int latency = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int nreads = 0, overlap = 0;
  logic [31:0] rd_a1, rd_a2;
  logic pend = 1'b0;
  logic [31:0] pend_addr;
  int pend_cnt = 0;

  function automatic logic [31:0] l1_desc(input int k);
    if (k == 4095) return {12'hABC, 18'h3FFFF, 2'b10};
    if (k >= 40) return 32'h0;
    case (k % 5)
      0: return 32'h0;
      1: return {12'((k * 37 + 5) & 12'hFFF), 18'h12345, 2'b10};
      3: return 32'hABCD_0003;
      default: return {22'(22'h000400 + k), 8'h3C, 2'b01};
    endcase
  endfunction

  function automatic logic [31:0] l2_desc(input int k, input int j);
    int g;
    g = j / 16;
    case (g % 4)
      0: return {16'((k * 131 + g * 17) & 16'hFFFF), 14'h2A5B, 2'b01};
      1: return 32'h1234_5600;
      default: return {20'((k * 977 + j * 13) & 20'hFFFFF), 10'h2AB, 1'b1, 1'(j & 1)};
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int k;
    logic [31:0] d;
    if (a >= L1_BASE && a < L1_BASE + 32'h4000) return l1_desc(int'((a - L1_BASE) >> 2));
    if (a >= L2_AREA && a < L2_AREA + 32'h0010_0000) begin
      k = int'((a - L2_AREA) >> 10);
      d = l1_desc(k);
      if (d[1:0] == 2'b01 && {d[31:10], 10'd0} == (a & 32'hFFFF_FC00))
        return l2_desc(k, int'((a >> 2) & 255));
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    mem_rerr <= 1'b0;
    if (mem_req) begin
      if (pend) overlap = overlap + 1;
      if (nreads == 0) rd_a1 = mem_addr; else rd_a2 = mem_addr;
      nreads = nreads + 1;
      pend <= 1'b1;
      pend_addr <= mem_addr;
      pend_cnt <= latency;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem_word(pend_addr);
        mem_rerr <= (pend_addr == err_addr);
        pend <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finish_run();
  end

  task automatic walk(input logic [31:0] va, input int lat, input logic [31:0] eaddr, input bit poke);
    logic [31:0] d1, d2, a1, a2, epa;
    logic [1:0] ecode;
    int ereads, w;
    string tag;
    a1 = L1_BASE + {18'd0, va[31:20], 2'b00};
    d1 = l1_desc(int'(va[31:20]));
    a2 = {d1[31:10], va[19:12], 2'b00};
    epa = '0; ereads = 1; ecode = 2'd0;
    if (a1 == eaddr) ecode = 2'd3;
    else if (d1[1:0] == 2'b10) epa = {d1[31:20], va[19:0]};
    else if (d1[1:0] == 2'b01) begin
      ereads = 2;
      d2 = l2_desc(int'(va[31:20]), int'(va[19:12]));
      if (a2 == eaddr) ecode = 2'd3;
      else if (d2[1:0] == 2'b00) ecode = 2'd2;
      else if (d2[1:0] == 2'b01) epa = {d2[31:16], va[15:0]};
      else epa = {d2[31:12], va[11:0]};
    end else ecode = 2'd1;
    if (ecode == 2'd3) tag = "R10";
    else if (ereads == 1) tag = (ecode == 2'd1) ? "R3" : "R4";
    else if (ecode == 2'd2) tag = "R6";
    else tag = (d2[1:0] == 2'b01) ? "R7" : "R8";

    @(negedge clk);
    latency = lat; err_addr = eaddr; nreads = 0; overlap = 0;
    req_va = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      req_va = ~va; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 50) begin @(negedge clk); w++; end
    chk("R9 done seen", {31'd0, done}, 32'd1);
    chk("R9 busy low at done", {31'd0, busy}, 32'd0);
    chk({tag, " fault_code"}, {30'd0, fault_code}, {30'd0, ecode});
    if (ecode == 2'd0) chk({tag, " phys_addr"}, phys_addr, epa);
    else chk("R9 fault_va", fault_va, va);
    chk(poke ? "R11 read count" : "R2 read count", nreads, ereads);
    chk("R2 l1 addr", rd_a1, a1);
    if (ereads == 2) chk("R5 l2 addr", rd_a2, a2);
    chk("R2 single outstanding", overlap, 0);
    @(negedge clk);
    chk("R9 done pulse", {31'd0, done}, 32'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R11 no late walk", {31'd0, busy}, 32'd0);
      chk("R11 reads after done", nreads, ereads);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 fault_code", {30'd0, fault_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 41; k++) begin
      for (int j = 0; j < 256; j += 7) begin
        automatic int kk = (k == 40) ? 4095 : k;
        walk({12'(kk), 8'(j), 12'((kk * 91 + j * 29) & 12'hFFF)}, (kk + j) % 3, 32'hFFFF_FFFF, 1'b0);
      end
    end
    for (int s = 0; s < 16; s++)
      walk({12'd2, 8'(s), 12'h5A5}, s % 3, 32'hFFFF_FFFF, 1'b0);
    walk({12'd2, 8'd40, 12'h123}, 2, 32'hFFFF_FFFF, 1'b1);
    walk({12'd1, 8'd3, 12'h777}, 1, 32'hFFFF_FFFF, 1'b1);
    walk({12'd6, 8'd3, 12'h010}, 0, L1_BASE + 32'd24, 1'b0);
    walk({12'd7, 8'd9, 12'h010}, 1, {22'(22'h000400 + 7), 8'd9, 2'b00}, 1'b0);
    walk({12'd1, 8'd0, 12'h0}, 2, L1_BASE + 32'd4, 1'b0);
    finish_run();
  end
endmodule